// File: doc/BRIEF.md
# Correlation-Based Radix Estimator for a Two-Channel Pipelined Converter

This block tracks the equivalent radix of one stage in each of two converter channels, and it does so while normal conversion keeps running. The two channels convert the same analog input with opposite polarity. Each channel also receives its own ±1 pseudorandom dither bit at the decision point of the stage under calibration, and the block produces those bits. For every sample, the block adds the two back-end output codes. Because the channels have opposite polarity, the input signal cancels in this sum and leaves a residual. The residual holds the dither contributions, quantization noise and other noise.

The block multiplies the residual by the sign of each channel's own dither bit and accumulates the product. Because the two dither sequences are uncorrelated, each channel's accumulator responds only to the error in that channel's radix estimate. Each estimate equals a programmable starting value plus the running correlation scaled by a power-of-two step size. The estimate is clamped to its own range and refreshed after every sample that is accepted. The block raises a sticky completion flag once a full run of samples has been absorbed. It keeps refining in the background afterwards, until a freeze input is held.

Top module: `radix_corr_cal`

## Requirements
- R1: After a synchronous active-high reset, `radix_pos` and `radix_neg` both equal `INIT_RADIX` (unsigned fixed point with `RADIX_FRAC` fraction bits). `est_valid` and `cal_done` are 0. `pn_pos` and `pn_neg` equal bit `LFSR_W-1` of `SEED_P` and `SEED_N` respectively.
- R2: Each dither sequence is an `LFSR_W`-bit shift register. The dither output is the register's top bit. On a cycle with `sample_valid` high, the register shifts left by one and takes in the XOR of its top bit and the tap bit. On any other cycle it holds, and so does the dither output.
- R3: The positive channel uses tap bit `TAP_P` (17 by default) and the negative channel uses tap bit `TAP_N` (4 by default). These give two different maximal-length sequences.
- R4: For each accepted, unfrozen sample, the residual is the sign-extended sum of `code_pos` and `code_neg`. A channel adds `+residual` to its 48-bit signed accumulator when its dither bit is 1, and `-residual` when it is 0. The dither bit used is the value shown on that cycle.
- R5: The channel's estimate becomes `INIT_RADIX + (accumulator >>> (STEP_EXP - RADIX_FRAC))`, using an arithmetic (floor) shift. The estimate appears on the port one cycle after the sample. `est_valid` is high in exactly the cycles that follow an unfrozen valid sample.
- R6: While `freeze` is high, valid samples leave both accumulators and both estimates unchanged and `est_valid` stays low. The dither sequences still advance.
- R7: An estimate whose value would fall below 0 reads 0. An estimate whose value would exceed `2^(RADIX_INT+RADIX_FRAC)-1` reads that maximum. The accumulator itself is not clamped.
- R8: `cal_done` rises in the cycle after the `2^RUN_LOG2`-th unfrozen sample and stays high until reset. Estimates keep updating after that.
- R9: A sample with `code_neg` equal to the negation of `code_pos` (input fully cancelled) leaves both estimates unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | A pair of channel codes is present this cycle |
| freeze | input | 1 | Hold accumulators and estimates |
| code_pos | input | CODE_W | Signed back-end code of the positive channel |
| code_neg | input | CODE_W | Signed back-end code of the negative channel |
| pn_pos | output | 1 | Dither bit for the positive channel (1 = +1, 0 = -1) |
| pn_neg | output | 1 | Dither bit for the negative channel (1 = +1, 0 = -1) |
| radix_pos | output | RADIX_INT+RADIX_FRAC | Radix estimate, positive channel |
| radix_neg | output | RADIX_INT+RADIX_FRAC | Radix estimate, negative channel |
| est_valid | output | 1 | Estimates were refreshed by the previous sample |
| cal_done | output | 1 | Sticky flag: a full run of samples has been absorbed |

## Verification
Every result the block produces is due one rising edge after its sample is presented. This covers the estimates, the strobe, the completion flag and the next dither bit. The bench presents inputs at the falling edge. At that moment it computes the post-edge values from its own dither, accumulator and clamp model and queues them. A monitor reads the ports 2 ns after the following rising edge and compares them with the head of the queue. The bench queues one item per cycle, including reset and idle cycles, so each item lines up with exactly the edge that produces it.

// File: rtl/radix_est_pkg.sv
`timescale 1ns/1ps
package radix_est_pkg;
  localparam int unsigned CH_COUNT = 2;
  localparam int unsigned CH_POS   = 0;
  localparam int unsigned CH_NEG   = 1;
endpackage

// File: rtl/rest_lfsr.sv
`timescale 1ns/1ps
// Fibonacci shift register producing one dither bit per accepted sample.
module rest_lfsr #(
  parameter int unsigned     W    = 23,
  parameter int unsigned     TAP  = 17,
  parameter logic [W-1:0]    SEED = W'(1)
) (
  input  logic clk,
  input  logic rst,
  input  logic adv,
  output logic seq_bit
);
  logic [W-1:0] st_q;

  always_ff @(posedge clk) begin
    if (rst)      st_q <= SEED;
    else if (adv) st_q <= {st_q[W-2:0], st_q[W-1] ^ st_q[TAP]};
  end

  assign seq_bit = st_q[W-1];
endmodule

// File: rtl/rest_corr_chan.sv
`timescale 1ns/1ps
// Sign-correlation accumulator and clamped radix estimate for one channel.
module rest_corr_chan #(
  parameter int unsigned          CODE_W   = 16,
  parameter int unsigned          ACC_W    = 48,
  parameter int unsigned          RADIX_W  = 23,
  parameter int unsigned          SHIFT    = 4,
  parameter logic [RADIX_W-1:0]   INIT_VAL = '0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     upd,
  input  logic                     pn,
  input  logic signed [CODE_W:0]   resid,
  output logic [RADIX_W-1:0]       radix
);
  localparam int unsigned PROD_W = CODE_W + 2;
  localparam int unsigned SUM_W  = ACC_W + 1;
  localparam logic signed [SUM_W-1:0] LIM_HI = $signed({{(SUM_W-RADIX_W){1'b0}}, {RADIX_W{1'b1}}});
  localparam logic signed [SUM_W-1:0] BASE   = $signed({{(SUM_W-RADIX_W){1'b0}}, INIT_VAL});

  logic signed [PROD_W-1:0] resid_x;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  acc_q;
  logic signed [ACC_W-1:0]  acc_d;
  logic signed [ACC_W-1:0]  acc_sh;
  logic signed [SUM_W-1:0]  total;
  logic [RADIX_W-1:0]       radix_d;

  always_comb begin
    resid_x = PROD_W'(resid);
    prod    = pn ? resid_x : -resid_x;
    acc_d   = acc_q + ACC_W'(prod);
    acc_sh  = acc_d >>> SHIFT;
    total   = SUM_W'(acc_sh) + BASE;
    if (total[SUM_W-1])     radix_d = '0;
    else if (total > LIM_HI) radix_d = '1;
    else                    radix_d = total[RADIX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      radix <= INIT_VAL;
    end else if (upd) begin
      acc_q <= acc_d;
      radix <= radix_d;
    end
  end
endmodule

// File: rtl/rest_run_ctr.sv
`timescale 1ns/1ps
// Counts absorbed samples; raises a sticky flag at the end of a full run.
module rest_run_ctr #(
  parameter int unsigned LOG2 = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  output logic done
);
  logic [LOG2-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      done  <= 1'b0;
    end else if (tick) begin
      cnt_q <= cnt_q + LOG2'(1);
      if (&cnt_q) done <= 1'b1;
    end
  end
endmodule

// File: rtl/radix_corr_cal.sv
`timescale 1ns/1ps
module radix_corr_cal #(
  parameter int unsigned              CODE_W     = 16,
  parameter int unsigned              ACC_W      = 48,
  parameter int unsigned              LFSR_W     = 23,
  parameter int unsigned              TAP_P      = 17,
  parameter int unsigned              TAP_N      = 4,
  parameter logic [LFSR_W-1:0]        SEED_P     = 23'h4A3B1C,
  parameter logic [LFSR_W-1:0]        SEED_N     = 23'h15C2E7,
  parameter int unsigned              RADIX_INT  = 3,
  parameter int unsigned              RADIX_FRAC = 20,
  parameter int unsigned              STEP_EXP   = 24,
  parameter int unsigned              RUN_LOG2   = 20,
  parameter int unsigned              INIT_RADIX = 2 << RADIX_FRAC
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              sample_valid,
  input  logic                              freeze,
  input  logic signed [CODE_W-1:0]          code_pos,
  input  logic signed [CODE_W-1:0]          code_neg,
  output logic                              pn_pos,
  output logic                              pn_neg,
  output logic [RADIX_INT+RADIX_FRAC-1:0]   radix_pos,
  output logic [RADIX_INT+RADIX_FRAC-1:0]   radix_neg,
  output logic                              est_valid,
  output logic                              cal_done
);
  import radix_est_pkg::*;

  localparam int unsigned RADIX_W = RADIX_INT + RADIX_FRAC;
  localparam int unsigned SHIFT   = STEP_EXP - RADIX_FRAC;

  logic                     upd;
  logic signed [CODE_W:0]   resid;
  logic [CH_COUNT-1:0]      seq_bits;
  logic [RADIX_W-1:0]       radix_arr [CH_COUNT];

  assign upd   = sample_valid & ~freeze;
  assign resid = (CODE_W+1)'(code_pos) + (CODE_W+1)'(code_neg);

  for (genvar g = 0; g < CH_COUNT; g++) begin : g_ch
    localparam int unsigned       TAP_G  = (g == CH_POS) ? TAP_P : TAP_N;
    localparam logic [LFSR_W-1:0] SEED_G = (g == CH_POS) ? SEED_P : SEED_N;

    rest_lfsr #(
      .W(LFSR_W), .TAP(TAP_G), .SEED(SEED_G)
    ) u_seq (
      .clk(clk), .rst(rst), .adv(sample_valid), .seq_bit(seq_bits[g])
    );

    rest_corr_chan #(
      .CODE_W(CODE_W), .ACC_W(ACC_W), .RADIX_W(RADIX_W),
      .SHIFT(SHIFT), .INIT_VAL(RADIX_W'(INIT_RADIX))
    ) u_corr (
      .clk(clk), .rst(rst), .upd(upd), .pn(seq_bits[g]),
      .resid(resid), .radix(radix_arr[g])
    );
  end

  rest_run_ctr #(.LOG2(RUN_LOG2)) u_run (
    .clk(clk), .rst(rst), .tick(upd), .done(cal_done)
  );

  always_ff @(posedge clk) begin
    if (rst) est_valid <= 1'b0;
    else     est_valid <= upd;
  end

  assign pn_pos    = seq_bits[CH_POS];
  assign pn_neg    = seq_bits[CH_NEG];
  assign radix_pos = radix_arr[CH_POS];
  assign radix_neg = radix_arr[CH_NEG];
endmodule

// File: rtl/radix_corr_cal_chk.sv
`timescale 1ns/1ps
module radix_corr_cal_chk #(
  parameter int unsigned CODE_W  = 16,
  parameter int unsigned RADIX_W = 23
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     sample_valid,
  input logic                     freeze,
  input logic signed [CODE_W-1:0] code_pos,
  input logic signed [CODE_W-1:0] code_neg,
  input logic                     pn_pos,
  input logic                     pn_neg,
  input logic [RADIX_W-1:0]       radix_pos,
  input logic [RADIX_W-1:0]       radix_neg,
  input logic                     est_valid,
  input logic                     cal_done
);
  logic signed [CODE_W:0] pair_sum;
  assign pair_sum = (CODE_W+1)'(code_pos) + (CODE_W+1)'(code_neg);

  a_r2_pn_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !sample_valid |=> ($stable(pn_pos) && $stable(pn_neg)));

  a_r5_strobe_cause: assert property (@(posedge clk) disable iff (rst)
    est_valid |-> $past(sample_valid && !freeze));

  a_r5_idle_radix_hold: assert property (@(posedge clk) disable iff (rst)
    !sample_valid |=> ($stable(radix_pos) && $stable(radix_neg)));

  a_r6_freeze_hold: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && freeze) |=> ($stable(radix_pos) && $stable(radix_neg) && !est_valid));

  a_r8_done_sticky: assert property (@(posedge clk) disable iff (rst)
    cal_done |=> cal_done);

  a_r9_cancel_no_move: assert property (@(posedge clk) disable iff (rst)
    (sample_valid && pair_sum == '0) |=> ($stable(radix_pos) && $stable(radix_neg)));
endmodule

bind radix_corr_cal radix_corr_cal_chk #(.CODE_W(CODE_W), .RADIX_W(RADIX_W)) u_chk (
  .clk(clk), .rst(rst), .sample_valid(sample_valid), .freeze(freeze),
  .code_pos(code_pos), .code_neg(code_neg), .pn_pos(pn_pos), .pn_neg(pn_neg),
  .radix_pos(radix_pos), .radix_neg(radix_neg), .est_valid(est_valid),
  .cal_done(cal_done)
);

// File: tb/radix_corr_cal_tb_top.sv
`timescale 1ns/1ps
module radix_corr_cal_tb_top;
  localparam int unsigned RW    = 23;
  localparam int unsigned RUNL  = 6;
  localparam int          RUN   = 1 << RUNL;
  localparam longint      INITV = 2 << 20;
  localparam longint      MAXV  = (64'd1 << RW) - 1;
  localparam logic [22:0] SP0   = 23'h4A3B1C;
  localparam logic [22:0] SN0   = 23'h15C2E7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sample_valid = 1'b0;
  logic freeze = 1'b0;
  logic signed [15:0] code_pos = '0;
  logic signed [15:0] code_neg = '0;
  logic pn_pos, pn_neg, est_valid, cal_done;
  logic [RW-1:0] radix_pos, radix_neg;

  always #4 clk = ~clk;

  radix_corr_cal #(.RUN_LOG2(RUNL)) dut_i (
    .clk(clk), .rst(rst), .sample_valid(sample_valid), .freeze(freeze),
    .code_pos(code_pos), .code_neg(code_neg), .pn_pos(pn_pos), .pn_neg(pn_neg),
    .radix_pos(radix_pos), .radix_neg(radix_neg), .est_valid(est_valid),
    .cal_done(cal_done)
  );

  typedef struct {
    string       tag;
    logic [22:0] rp;
    logic [22:0] rn;
    bit          ev;
    bit          pp;
    bit          pq;
    bit          dn;
  } exp_t;

  exp_t   sb_q[$];
  int     n_checks = 0;
  int     n_fail   = 0;
  bit     finished = 0;

  // bench model state
  logic [22:0] m_sp, m_sn;
  longint      m_ap, m_an, m_rp, m_rn;
  int          m_cnt;
  bit          m_done, m_ev;

  function automatic longint clampv(longint v);
    if (v < 0) return 0;
    if (v > MAXV) return MAXV;
    return v;
  endfunction

  task automatic step(input bit r, input bit v, input bit f, input int p, input int n, input string tag);
    exp_t e;
    longint sum;
    @(negedge clk);
    rst = r; sample_valid = v; freeze = f;
    code_pos = 16'(p); code_neg = 16'(n);
    if (r) begin
      m_sp = SP0; m_sn = SN0; m_ap = 0; m_an = 0;
      m_rp = INITV; m_rn = INITV; m_cnt = 0; m_done = 0; m_ev = 0;
    end else if (v) begin
      sum = longint'(code_pos) + longint'(code_neg);
      if (!f) begin
        m_ap += m_sp[22] ? sum : -sum;
        m_an += m_sn[22] ? sum : -sum;
        m_rp = clampv(INITV + (m_ap >>> 4));
        m_rn = clampv(INITV + (m_an >>> 4));
        m_cnt++;
        if (m_cnt >= RUN) m_done = 1;
      end
      m_ev = !f;
      m_sp = {m_sp[21:0], m_sp[22] ^ m_sp[17]};
      m_sn = {m_sn[21:0], m_sn[22] ^ m_sn[4]};
    end else begin
      m_ev = 0;
    end
    e.tag = tag; e.rp = 23'(m_rp); e.rn = 23'(m_rn); e.ev = m_ev;
    e.pp = m_sp[22]; e.pq = m_sn[22]; e.dn = m_done;
    sb_q.push_back(e);
  endtask

  // monitor
  initial begin
    exp_t e;
    forever begin
      @(posedge clk); #2;
      if (sb_q.size() > 0) begin
        e = sb_q.pop_front();
        n_checks++;
        if (radix_pos !== e.rp || radix_neg !== e.rn || est_valid !== e.ev ||
            pn_pos !== e.pp || pn_neg !== e.pq || cal_done !== e.dn) begin
          n_fail++;
          $display("FAIL %s: act rp=%h rn=%h ev=%b pp=%b pn=%b dn=%b exp rp=%h rn=%h ev=%b pp=%b pn=%b dn=%b",
                   e.tag, radix_pos, radix_neg, est_valid, pn_pos, pn_neg, cal_done,
                   e.rp, e.rn, e.ev, e.pp, e.pq, e.dn);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: act timeout exp completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int x;
    // R1: reset state
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, "R1 reset");
    // R2: idle cycles hold sequences and estimates
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, "R2 idle hold");
    // R4/R5: single sample, small residual, floor shift
    step(0, 1, 0, 1000, -900, "R4 single residual");
    step(0, 0, 0, 0, 0, "R5 strobe drops");
    // R9: cancelled input leaves estimates alone
    for (int i = 0; i < 30; i++) begin
      x = (i * 7919) % 30000 - 15000;
      step(0, 1, 0, x, -x, "R9 cancelled input");
    end
    // R2/R3/R4: mixed residual patterns, interleaved gaps
    for (int i = 0; i < 50; i++) begin
      x = (i * 4099) % 20000 - 10000;
      step(0, 1, 0, x, -x + (m_sp[22] ? 37 : -37) + (m_sn[22] ? -11 : 11) + (i % 5) - 2,
           "R4 correlated residual");
      if (i % 7 == 3) step(0, 0, 0, 123, 456, "R2 gap hold");
    end
    // R6: freeze with large residual
    for (int i = 0; i < 12; i++) step(0, 1, 1, 20000, 9000, "R6 freeze hold");
    // R8: reach a full run and keep updating
    for (int i = 0; i < 20; i++) step(0, 1, 0, 500 + i, 300, "R8 run done");
    // R7: saturate high then low
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, "R1 reset again");
    for (int i = 0; i < 2100; i++) begin
      if (m_sp[22]) step(0, 1, 0, 32767, 32767, "R7 clamp high");
      else          step(0, 1, 0, -32768, -32768, "R7 clamp high");
    end
    for (int i = 0; i < 2800; i++) begin
      if (m_sp[22]) step(0, 1, 0, -32768, -32768, "R7 clamp low");
      else          step(0, 1, 0, 32767, 32767, "R7 clamp low");
    end
    step(0, 0, 0, 0, 0, "R7 settle");
    repeat (3) @(posedge clk);
    #3;
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule